// File: doc/BRIEF.md
# Byte-wide SPI controller with status flags

This block is a serial peripheral port that moves one byte at a time over a four-wire serial bus. A CPU reaches it through a small register interface with four addresses. The port runs either as bus master, generating the serial clock from the system clock, or as a slave, following a clock and select from another master. No holding buffer sits in front of the shifter: a CPU write to the data address loads the shifter directly, and in master mode that write also starts the byte. Reads of the same address return the last byte received.

A status register reports three sticky flags: byte finished, write collision (a data write that arrived while a byte was in flight) and mode fault (the select input pulled active while the port is master). One read of the status register clears all three. When enabled, the byte-finished flag drives an interrupt line. On a mode fault the port leaves master mode on its own and releases its clock and data outputs.

Register map: address 0 is control (bit 0 phase, bit 1 clock idle level, bit 2 master, bit 3 interrupt enable, upper bits read 0); address 1 is status (read only); address 2 is data (write: shifter, read: receive buffer); address 3 is the clock divider.

Top module: `spi_port`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00, divider reads 0x03, the receive buffer reads 0x00, irq_o is 0 and sclk_oe_o, mosi_oe_o and miso_oe_o are 0.
- R2: In master mode (control bit 2 = 1), a write to address 2 while idle loads the shifter and starts an 8-bit transfer, MSB first on mosi_o; each half-period of sclk_o lasts (divider + 1) system clocks.
- R3: In master mode sclk_o rests at the level of control bit 1 when idle; with control bit 0 = 0 data is sampled on the first (leading) clock edge of each bit, with bit 0 = 1 on the second (trailing) edge.
- R4: The byte shifted in during a transfer is captured in the receive buffer and returned by a read of address 2.
- R5: Status bit 7 is set at the end of every byte, in master mode and in slave mode.
- R6: In slave mode (control bit 2 = 0), with ss_n_i low, the port drives miso_o (miso_oe_o = 1) with the byte last written to address 2, MSB first, and samples mosi_i on the edges chosen by control bits 1 and 0.
- R7: A write to address 2 while a byte is in flight sets status bit 6 and leaves the byte being shifted unchanged.
- R8: When ss_n_i is low while the port is master, status bit 4 is set, control bit 2 is cleared, and sclk_oe_o and mosi_oe_o go to 0.
- R9: A read of address 1 returns 0 in bits 5 and 3..0 and clears bits 7, 6 and 4; a flag event in the same cycle as the read wins, and the flag is set afterwards.
- R10: irq_o is 1 exactly while control bit 3 and status bit 7 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe (side effects on status only) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe_o | output | 1 | Output enable for sclk_o |
| mosi_o | output | 1 | Master data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Master data in |
| miso_o | output | 1 | Slave data out |
| miso_oe_o | output | 1 | Output enable for miso_o |
| sclk_i | input | 1 | Serial clock from an external master |
| mosi_i | input | 1 | Slave data in |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The byte-finished flag can be raised by the end of a transfer in the very cycle a status read is clearing the flags. The bench provokes this by holding the read strobe on the status address continuously from the cycle before the flag is due, so one read lands exactly on the setting cycle. It then counts, over the held reads, how many returned bit 7 as 1: exactly one read must see it, which shows the set won over the clear and that the following read cleared it. A write collision raised during a transfer is checked in the same way through the status value read afterwards.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    // register addresses; the data address is shared by transmit and receive
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_DIV  = 2'd3
    } reg_addr_e;

    // packed so that the struct lines up with control bits 3..0
    typedef struct packed {
        logic ie;
        logic master;
        logic cpol;
        logic cpha;
    } ctrl_t;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_WCOL_BIT = 6;
    localparam int STAT_MODF_BIT = 4;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t q, d;

    always_comb begin
        d = q;
        if (!run || q.cnt == div) d.cnt = '0;
        else                      d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = run && (q.cnt == div);

endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    input  logic              ss_act,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              miso_i,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              modf,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk_o,
    output logic              tx_bit
);

    localparam int              EDGES = 2 * DATA_W;
    localparam int              CNT_W = $clog2(EDGES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    typedef struct packed {
        logic              run;
        logic              sclk;
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              done;
        logic              modf;
    } eng_t;

    eng_t q, d;
    logic edge_ev;
    logic din;
    logic sample_edge;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.modf      = 1'b0;
        d.sclk_prev = sclk_s;
        edge_ev     = 1'b0;
        din         = miso_i;

        if (is_master) begin
            if (!q.run) d.sclk = cpol;
            if (ss_act) begin
                // another master owns the bus: abort and report
                d.run  = 1'b0;
                d.cnt  = '0;
                d.sclk = cpol;
                d.modf = 1'b1;
            end else if (!q.run) begin
                if (load) begin
                    d.tx  = load_data;
                    d.run = 1'b1;
                    d.cnt = '0;
                end
            end else begin
                edge_ev = tick;
            end
        end else begin
            d.sclk = cpol;
            d.run  = 1'b0;
            din    = mosi_s;
            if (!ss_act) begin
                d.cnt = '0;
                if (load) d.tx = load_data;
            end else begin
                if (load && q.cnt == '0) d.tx = load_data;
                edge_ev = (sclk_s != q.sclk_prev);
            end
        end

        // even edge counts are leading edges; phase picks the sampling one
        sample_edge = (~q.cnt[0]) ^ cpha;

        if (edge_ev) begin
            if (is_master) d.sclk = ~q.sclk;
            if (sample_edge) begin
                d.rx = {q.rx[DATA_W-2:0], din};
            end else if (!(cpha && q.cnt == '0)) begin
                d.tx = {q.tx[DATA_W-2:0], 1'b0};
            end
            if (q.cnt == LAST) begin
                d.cnt  = '0;
                d.run  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run     = q.run;
    assign busy    = is_master ? q.run : (ss_act && q.cnt != '0);
    assign done    = q.done;
    assign modf    = q.modf;
    assign rx_byte = q.rx;
    assign sclk_o  = q.sclk;
    assign tx_bit  = q.tx[DATA_W-1];

endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_port_pkg::*;
#(
    parameter int               DATA_W  = 8,
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              evt_done,
    input  logic              evt_modf,
    input  logic [DATA_W-1:0] rx_byte,
    output ctrl_t             cfg,
    output logic [DIV_W-1:0]  div,
    output logic              load,
    output logic              evt_wcol,
    output logic              stat_spif,
    output logic              stat_wcol,
    output logic              stat_modf,
    output logic              irq
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rxbuf;
        logic              spif;
        logic              wcol;
        logic              modf;
    } reg_t;

    reg_t q, d;
    logic wr_data;
    logic [DATA_W-1:0] stat_vec;

    assign wr_data  = bus_wr && (bus_addr == REG_DATA);
    assign load     = wr_data && !busy;
    assign evt_wcol = wr_data && busy;

    always_comb begin
        d = q;
        if (bus_wr && bus_addr == REG_CTRL) d.ctrl = ctrl_t'(bus_wdata[3:0]);
        if (bus_wr && bus_addr == REG_DIV)  d.div  = DIV_W'(bus_wdata);
        if (bus_rd && bus_addr == REG_STAT) begin
            d.spif = 1'b0;
            d.wcol = 1'b0;
            d.modf = 1'b0;
        end
        // events are applied last so that they win over a clearing read
        if (evt_done) begin
            d.spif  = 1'b1;
            d.rxbuf = rx_byte;
        end
        if (evt_wcol) d.wcol = 1'b1;
        if (evt_modf) begin
            d.modf        = 1'b1;
            d.ctrl.master = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.div  <= DIV_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        stat_vec                = '0;
        stat_vec[STAT_DONE_BIT] = q.spif;
        stat_vec[STAT_WCOL_BIT] = q.wcol;
        stat_vec[STAT_MODF_BIT] = q.modf;
        case (bus_addr)
            REG_CTRL: bus_rdata = DATA_W'(q.ctrl);
            REG_STAT: bus_rdata = stat_vec;
            REG_DATA: bus_rdata = q.rxbuf;
            default:  bus_rdata = DATA_W'(q.div);
        endcase
    end

    assign cfg       = q.ctrl;
    assign div       = q.div;
    assign stat_spif = q.spif;
    assign stat_wcol = q.wcol;
    assign stat_modf = q.modf;
    assign irq       = q.ctrl.ie && q.spif;

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int               DATA_W      = 8,
    parameter int               DIV_W       = 8,
    parameter logic [DIV_W-1:0] DIV_RST     = 3,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              ss_n_i
);

    ctrl_t             cfg;
    logic [DIV_W-1:0]  div;
    logic              load;
    logic              busy;
    logic              run;
    logic              tick;
    logic              evt_done;
    logic              evt_wcol;
    logic              evt_modf;
    logic              stat_spif;
    logic              stat_wcol;
    logic              stat_modf;
    logic [DATA_W-1:0] rx_byte;
    logic              ss_n_s;
    logic              sclk_s;
    logic              mosi_s;
    logic              ss_act;
    logic              tx_bit;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n_i, sclk_i, mosi_i}),
        .dout ({ss_n_s, sclk_s, mosi_s})
    );

    assign ss_act = ~ss_n_s;

    spi_regs #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .DIV_RST(DIV_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy),
        .evt_done (evt_done),
        .evt_modf (evt_modf),
        .rx_byte  (rx_byte),
        .cfg      (cfg),
        .div      (div),
        .load     (load),
        .evt_wcol (evt_wcol),
        .stat_spif(stat_spif),
        .stat_wcol(stat_wcol),
        .stat_modf(stat_modf),
        .irq      (irq_o)
    );

    spi_clkdiv #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div),
        .tick (tick)
    );

    spi_engine #(
        .DATA_W(DATA_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_master(cfg.master),
        .cpol     (cfg.cpol),
        .cpha     (cfg.cpha),
        .load     (load),
        .load_data(bus_wdata),
        .tick     (tick),
        .ss_act   (ss_act),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .miso_i   (miso_i),
        .run      (run),
        .busy     (busy),
        .done     (evt_done),
        .modf     (evt_modf),
        .rx_byte  (rx_byte),
        .sclk_o   (sclk_o),
        .tx_bit   (tx_bit)
    );

    assign sclk_oe_o = cfg.master;
    assign mosi_oe_o = cfg.master;
    assign mosi_o    = tx_bit;
    assign miso_o    = tx_bit;
    assign miso_oe_o = !cfg.master && ss_act;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input ctrl_t             cfg,
    input logic              busy,
    input logic              evt_done,
    input logic              evt_wcol,
    input logic              evt_modf,
    input logic              stat_spif,
    input logic              stat_wcol,
    input logic              stat_modf,
    input logic              sclk_o,
    input logic              sclk_oe_o,
    input logic              mosi_oe_o,
    input logic              irq_o
);

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.master && !busy && $stable(cfg)) |-> (sclk_o == cfg.cpol));

    assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> stat_spif);

    assert_wcol_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA && busy) |=> stat_wcol);

    assert_modf_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_modf) |-> (!sclk_oe_o && !mosi_oe_o));

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_STAT) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'd0));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_STAT && !evt_done && !evt_wcol && !evt_modf)
        |=> (!stat_spif && !stat_wcol && !stat_modf));

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && cfg.ie && !(bus_wr && bus_addr == REG_CTRL)) |=> irq_o);

endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .cfg      (cfg),
    .busy     (busy),
    .evt_done (evt_done),
    .evt_wcol (evt_wcol),
    .evt_modf (evt_modf),
    .stat_spif(stat_spif),
    .stat_wcol(stat_wcol),
    .stat_modf(stat_modf),
    .sclk_o   (sclk_o),
    .sclk_oe_o(sclk_oe_o),
    .mosi_oe_o(mosi_oe_o),
    .irq_o    (irq_o)
);

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;
    localparam int         HALF   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_o, sclk_o, sclk_oe_o, mosi_o, mosi_oe_o;
    logic       miso_o, miso_oe_o;
    logic       miso_i = 1'b0;
    logic       sclk_i = 1'b0;
    logic       mosi_i = 1'b0;
    logic       ss_n_i = 1'b1;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
        .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .sclk_i(sclk_i),
        .mosi_i(mosi_i), .ss_n_i(ss_n_i)
    );

    function automatic logic [7:0] exp_stat(input bit done, input bit wcol, input bit modf);
        return {done, wcol, 1'b0, modf, 4'b0000};
    endfunction

    function automatic logic [7:0] ctrl_word(input bit ie, input bit mst, input bit cpol, input bit cpha);
        return {4'b0000, ie, mst, cpol, cpha};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic master_xfer(input logic [7:0] tb, input logic [7:0] sb, input bit cpol,
                               input bit cpha, input bit ie, input logic [7:0] dv,
                               input bit poll, input bit wcol_mid);
        logic [7:0] got;
        logic [7:0] v;
        int bi;
        int seen;
        realtime t0, t1;
        bus_write(A_DIV, dv);
        bus_write(A_CTRL, ctrl_word(ie, 1'b1, cpol, cpha));
        repeat (2) @(negedge clk);
        chk(sclk_o == cpol, "R3 idle level", sclk_o, cpol);
        chk(sclk_oe_o && mosi_oe_o, "R2 master enables", sclk_oe_o, 1);
        miso_i = cpha ? 1'b0 : sb[7];
        bi  = cpha ? 8 : 7;
        got = 8'd0;
        t0 = 0; t1 = 0;
        bus_write(A_DATA, tb);
        if (wcol_mid) bus_write(A_DATA, ~tb);
        for (int e = 0; e < 16; e++) begin
            @(sclk_o);
            if (e == 0) t0 = $realtime;
            if (e == 1) t1 = $realtime;
            #1;
            if (((e % 2) == 0) ^ cpha) got = {got[6:0], mosi_o};
            else begin
                bi--;
                if (bi >= 0) miso_i = sb[bi];
            end
        end
        chk((t1 - t0) == real'(dv + 1) * 5.0, "R2 half period", int'(t1 - t0), (dv + 1) * 5);
        chk(got == tb, wcol_mid ? "R7 byte in flight kept" : "R2 mosi byte", got, tb);
        if (poll) begin
            // hold a status read across the cycle in which the flag is raised
            seen = 0;
            @(negedge clk);
            bus_rd = 1'b1; bus_addr = A_STAT;
            for (int k = 0; k < 6; k++) begin
                #1;
                if (bus_rdata[7]) seen++;
                @(negedge clk);
            end
            bus_rd = 1'b0;
            chk(seen == 1, "R9 set wins over clear, R5", seen, 1);
        end else begin
            repeat (2) @(negedge clk);
            chk(irq_o == ie, "R10 irq with flag", irq_o, ie);
            bus_read(A_STAT, v);
            chk(v == exp_stat(1'b1, wcol_mid, 1'b0), "R5 status after byte", v, exp_stat(1'b1, wcol_mid, 1'b0));
            chk(irq_o == 1'b0, "R10 irq after clear", irq_o, 0);
            bus_read(A_STAT, v);
            chk(v == 8'h00, "R9 flags cleared", v, 0);
        end
        bus_read(A_DATA, v);
        chk(v == sb, "R4 receive buffer", v, sb);
    endtask

    task automatic slave_xfer(input logic [7:0] mb, input logic [7:0] lb, input bit cpol, input bit cpha);
        logic [7:0] got;
        logic [7:0] v;
        bus_write(A_CTRL, ctrl_word(1'b0, 1'b0, cpol, cpha));
        bus_write(A_DATA, lb);
        sclk_i = cpol; mosi_i = 1'b0;
        repeat (4) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(miso_oe_o == 1'b1, "R6 miso enabled", miso_oe_o, 1);
        got = 8'd0;
        for (int b = 0; b < 8; b++) begin
            if (!cpha) mosi_i = mb[7-b];
            repeat (HALF) @(negedge clk);
            if (!cpha) got = {got[6:0], miso_o};
            sclk_i = ~sclk_i;
            if (cpha) mosi_i = mb[7-b];
            repeat (HALF) @(negedge clk);
            if (cpha) got = {got[6:0], miso_o};
            sclk_i = ~sclk_i;
        end
        repeat (6) @(negedge clk);
        chk(got == lb, "R6 slave miso byte", got, lb);
        bus_read(A_STAT, v);
        chk(v == exp_stat(1'b1, 1'b0, 1'b0), "R5 slave done flag", v, exp_stat(1'b1, 1'b0, 1'b0));
        ss_n_i = 1'b1;
        bus_read(A_DATA, v);
        chk(v == mb, "R4 R6 slave receive", v, mb);
        repeat (4) @(negedge clk);
        chk(miso_oe_o == 1'b0, "R6 miso released", miso_oe_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_CTRL, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
        bus_read(A_STAT, v); chk(v == 8'h00, "R1 status reset", v, 0);
        bus_read(A_DIV, v);  chk(v == 8'h03, "R1 divider reset", v, 3);
        bus_read(A_DATA, v); chk(v == 8'h00, "R1 rx reset", v, 0);
        chk(irq_o == 1'b0 && sclk_oe_o == 1'b0 && mosi_oe_o == 1'b0 && miso_oe_o == 1'b0,
            "R1 outputs idle", {irq_o, sclk_oe_o, mosi_oe_o, miso_oe_o}, 0);

        // directed: all four clock modes as master, fastest and slow divider
        master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b0);
        master_xfer(8'h81, 8'h7E, 1'b0, 1'b1, 1'b0, 8'd2, 1'b1, 1'b0);
        master_xfer(8'h01, 8'h80, 1'b1, 1'b0, 1'b1, 8'd5, 1'b0, 1'b0);
        master_xfer(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'd1, 1'b1, 1'b0);

        // R7 write collision while a byte is in flight
        master_xfer(8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b1);

        // R8 mode fault
        bus_write(A_CTRL, ctrl_word(1'b0, 1'b1, 1'b0, 1'b0));
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(!sclk_oe_o && !mosi_oe_o, "R8 outputs released", {sclk_oe_o, mosi_oe_o}, 0);
        bus_read(A_STAT, v);
        chk(v == exp_stat(1'b0, 1'b0, 1'b1), "R8 mode fault flag", v, exp_stat(1'b0, 1'b0, 1'b1));
        bus_read(A_CTRL, v);
        chk(v[2] == 1'b0, "R8 master bit cleared", v, 0);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(A_STAT, v);
        chk(v == 8'h00, "R9 status clear after fault", v, 0);

        // R6 slave mode, all four clock modes
        for (int m = 0; m < 4; m++) begin
            slave_xfer(8'($urandom), 8'($urandom), m[1], m[0]);
        end

        // constrained random master transfers
        for (int n = 0; n < 16; n++) begin
            master_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        8'($urandom % 4), 1'($urandom), 1'b0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule